// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block is the control core of a programmable clock generator. It decides which divider pair (N, M) and which output ratio code are handed to the frequency synthesizer. There are three possible sources. A latched 5-bit strap code is decoded arithmetically into a divider pair. A software-programmed pair can be enabled. A recovery setting takes over on its own when a watchdog time-out pulse arrives. A separate override bit chooses whether the ratio code follows the strap code or a software select field.

Software reaches the block through a byte-wide write port with address, data and write-enable, and reads it back through a combinational read port. The programmable pair is staged: writing its N byte only stores the value, and writing its M byte transfers both halves to the synthesizer. The recovery registers act at once whenever recovery is in force. Each time the selected N, M or ratio changes, a one-cycle load strobe tells the synthesizer to retune. The strobe stays low when nothing changes.

Top module: `clk_src_sel`

## Requirements
- R1: While reset is held and directly after it, every register reads back 0, recovery is inactive, `load_stb` is 0, and the outputs show the strap-derived pair together with the strap code as ratio.
- R2: With recovery inactive and the enable bit (address 4, bit 0) clear, `pll_n` equals 50 + 6 × `strap_code` (modulo 256) and `pll_m` equals 48.
- R3: With the override bit (address 4, bit 1) clear, `ratio_code` equals `strap_code`. With it set, `ratio_code` equals the select field at address 5, bits 4:0. This holds whichever N/M source is active.
- R4: With the enable bit set and recovery inactive, `pll_n`/`pll_m` show the loaded pair. A write to the programmable M byte (address 3, bits 6:0) loads the current programmable N (address 2) together with the new M. A write to address 2 alone leaves the loaded pair and the outputs unchanged.
- R5: A one-cycle `wdt_tmo` pulse makes recovery active (read back at address 4, bit 2). While recovery is active it takes priority over the programmable pair and the strap pair.
- R6: While recovery is active, the source flag (address 1, bit 7) picks the pair. If the flag is 0, the strap pair is used. If it is 1, recovery N (address 0) and recovery M (address 1, bits 6:0) are used, and a write to either register changes the outputs without any further action.
- R7: Writing address 4 with bit 2 set clears recovery. If `wdt_tmo` arrives in the same cycle, recovery stays active.
- R8: The outputs and `load_stb` update on the clock edge after the one that changed the source state. `load_stb` is high for exactly that one cycle per change.
- R9: A write or input change that leaves the selected N, M and ratio the same produces no `load_stb`.
- R10: Writes to addresses 6 and 7 change no register and no output, and those addresses read as 0. Mapped registers read back as written; unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data byte, combinational |
| strap_code | input | 5 | Latched strap frequency code |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| pll_n | output | 8 | Selected N divider |
| pll_m | output | 7 | Selected M divider |
| ratio_code | output | 5 | Selected output ratio code |
| load_stb | output | 1 | One-cycle retune strobe |

## Verification
A register write becomes visible on `rd_data` directly after the edge that takes the write. The selected N, M, ratio and `load_stb` follow one edge later, so the total latency from a write or a time-out pulse to the outputs is two edges. The bench drives every input on a falling edge. It reads registers on the next falling edge and checks the outputs and the strobe one falling edge after that, comparing against a shadow model computed from the requirements. A strap code change reaches the outputs after a single edge, and the bench samples it on the first falling edge after that edge.

// File: rtl/clksel_pkg.sv
// Shared constants for the clock source selector: byte bus width,
// register addresses and control bit positions.
package clksel_pkg;
    localparam int BUS_W        = 8;
    localparam int ADDR_W       = 3;
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_OVR_BIT  = 1;
    localparam int CTL_REC_BIT  = 2;
    localparam int SRC_FLAG_BIT = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_RECN = 3'd0,
        A_RECM = 3'd1,
        A_PRGN = 3'd2,
        A_PRGM = 3'd3,
        A_CTRL = 3'd4,
        A_SEL  = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/clksel_regs.sv
// Register bank for the clock source selector.
// Holds the recovery pair and its source flag, the programmable pair with a
// staged copy that M writes load, the control and select fields, and the
// recovery-active state. Assumes NW <= 8 and MW <= 7 so that the flag fits bit 7.
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int NW = 8,
    parameter int MW = 7,
    parameter int CW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    input  logic              wdt_tmo,
    output logic [NW-1:0]     rec_n,
    output logic [MW-1:0]     rec_m,
    output logic              rec_flag,
    output logic [NW-1:0]     ld_n,
    output logic [MW-1:0]     ld_m,
    output logic              prg_en,
    output logic              ovr_en,
    output logic [CW-1:0]     sw_sel,
    output logic              rec_act
);
    logic [NW-1:0] prg_n;
    logic [MW-1:0] prg_m;
    logic          clr_hit;

    assign clr_hit = wr_en && (wr_addr == A_CTRL) && wr_data[CTL_REC_BIT];

    // Purpose: capture byte writes into the mapped registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_n    <= '0;
            rec_m    <= '0;
            rec_flag <= 1'b0;
            prg_n    <= '0;
            prg_m    <= '0;
            ld_n     <= '0;
            ld_m     <= '0;
            prg_en   <= 1'b0;
            ovr_en   <= 1'b0;
            sw_sel   <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_RECN: rec_n <= wr_data[NW-1:0];
                A_RECM: begin
                    rec_m    <= wr_data[MW-1:0];
                    rec_flag <= wr_data[SRC_FLAG_BIT];
                end
                A_PRGN: prg_n <= wr_data[NW-1:0];
                A_PRGM: begin
                    prg_m <= wr_data[MW-1:0];
                    ld_n  <= prg_n;
                    ld_m  <= wr_data[MW-1:0];
                end
                A_CTRL: begin
                    prg_en <= wr_data[CTL_EN_BIT];
                    ovr_en <= wr_data[CTL_OVR_BIT];
                end
                A_SEL:  sw_sel <= wr_data[CW-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: enter recovery on a time-out, leave it on a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       rec_act <= 1'b0;
        else if (wdt_tmo) rec_act <= 1'b1;
        else if (clr_hit) rec_act <= 1'b0;
    end

    // Purpose: combinational read-back; unmapped addresses and unused bits read 0.
    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            A_RECN: rd_data[NW-1:0] = rec_n;
            A_RECM: begin
                rd_data[MW-1:0]       = rec_m;
                rd_data[SRC_FLAG_BIT] = rec_flag;
            end
            A_PRGN: rd_data[NW-1:0] = prg_n;
            A_PRGM: rd_data[MW-1:0] = prg_m;
            A_CTRL: begin
                rd_data[CTL_EN_BIT]  = prg_en;
                rd_data[CTL_OVR_BIT] = ovr_en;
                rd_data[CTL_REC_BIT] = rec_act;
            end
            A_SEL:  rd_data[CW-1:0] = sw_sel;
            default: rd_data = '0;
        endcase
    end

    AST_TMO_ENTERS_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tmo |=> rec_act); // R5
    AST_W1C_LEAVES_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !wdt_tmo) |=> !rec_act); // R7
    AST_PRGN_KEEPS_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PRGN) |=> $stable({ld_n, ld_m})); // R4
    AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > A_SEL) |=> $stable({rec_n, rec_m, rec_flag, prg_n, prg_m,
                                                ld_n, ld_m, prg_en, ovr_en, sw_sel})); // R10
endmodule

// File: rtl/clksel_mux.sv
// Priority source selection.
// Decodes the strap code into a divider pair arithmetically and picks, in
// priority order, the recovery source, the loaded programmable pair, or the strap
// pair. Independently of that, it picks the ratio code from the strap or the
// select field. Purely combinational.
module clksel_mux #(
    parameter int NW     = 8,
    parameter int MW     = 7,
    parameter int CW     = 5,
    parameter int N_BASE = 50,
    parameter int N_STEP = 6,
    parameter int M_FIX  = 48
) (
    input  logic [CW-1:0] strap_code,
    input  logic [NW-1:0] rec_n,
    input  logic [MW-1:0] rec_m,
    input  logic          rec_flag,
    input  logic          rec_act,
    input  logic [NW-1:0] ld_n,
    input  logic [MW-1:0] ld_m,
    input  logic          prg_en,
    input  logic          ovr_en,
    input  logic [CW-1:0] sw_sel,
    output logic [NW-1:0] nxt_n,
    output logic [MW-1:0] nxt_m,
    output logic [CW-1:0] nxt_r
);
    logic [NW-1:0] strap_n;
    logic [MW-1:0] strap_m;

    assign strap_n = NW'(N_BASE) + NW'(N_STEP) * NW'(strap_code);
    assign strap_m = MW'(M_FIX);

    // Purpose: choose the divider pair by source priority.
    always_comb begin
        if (rec_act && rec_flag) begin
            nxt_n = rec_n;
            nxt_m = rec_m;
        end else if (rec_act) begin
            nxt_n = strap_n;
            nxt_m = strap_m;
        end else if (prg_en) begin
            nxt_n = ld_n;
            nxt_m = ld_m;
        end else begin
            nxt_n = strap_n;
            nxt_m = strap_m;
        end
    end

    // Purpose: choose the ratio code from the override bit.
    always_comb begin
        nxt_r = ovr_en ? sw_sel : strap_code;
    end
endmodule

// File: rtl/clksel_out.sv
// Output stage: registers the selected bus and raises a one-cycle strobe on
// each edge where the registered value changes. Assumes the bus is the
// concatenation of N, M and ratio. During reset it tracks the selection silently.
module clksel_out #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q,
    output logic         load_stb
);
    // Purpose: hold the selection and flag every change with one strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= nxt;
            load_stb <= 1'b0;
        end else begin
            q        <= nxt;
            load_stb <= (nxt != q);
        end
    end

    AST_CHANGE_GIVES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && q != $past(q)) |-> load_stb); // R8
    AST_STROBE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && load_stb) |-> (q != $past(q))); // R9
endmodule

// File: rtl/clk_src_sel.sv
// Top of the clock frequency source selector: register bank, priority mux
// and output stage. Assumes inputs are synchronous to clk and wdt_tmo is a
// single-cycle pulse.
module clk_src_sel
    import clksel_pkg::*;
#(
    parameter int NW     = 8,
    parameter int MW     = 7,
    parameter int CW     = 5,
    parameter int N_BASE = 50,
    parameter int N_STEP = 6,
    parameter int M_FIX  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [CW-1:0]     strap_code,
    input  logic              wdt_tmo,
    output logic [NW-1:0]     pll_n,
    output logic [MW-1:0]     pll_m,
    output logic [CW-1:0]     ratio_code,
    output logic              load_stb
);
    localparam int OUT_W = NW + MW + CW;

    logic [NW-1:0]    rec_n, ld_n, nxt_n;
    logic [MW-1:0]    rec_m, ld_m, nxt_m;
    logic [CW-1:0]    sw_sel, nxt_r;
    logic             rec_flag, prg_en, ovr_en, rec_act;
    logic [OUT_W-1:0] out_q;

    clksel_regs #(.NW(NW), .MW(MW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wdt_tmo(wdt_tmo), .rec_n(rec_n), .rec_m(rec_m), .rec_flag(rec_flag),
        .ld_n(ld_n), .ld_m(ld_m), .prg_en(prg_en), .ovr_en(ovr_en),
        .sw_sel(sw_sel), .rec_act(rec_act)
    );

    clksel_mux #(.NW(NW), .MW(MW), .CW(CW), .N_BASE(N_BASE),
                 .N_STEP(N_STEP), .M_FIX(M_FIX)) u_mux (
        .strap_code(strap_code), .rec_n(rec_n), .rec_m(rec_m),
        .rec_flag(rec_flag), .rec_act(rec_act), .ld_n(ld_n), .ld_m(ld_m),
        .prg_en(prg_en), .ovr_en(ovr_en), .sw_sel(sw_sel),
        .nxt_n(nxt_n), .nxt_m(nxt_m), .nxt_r(nxt_r)
    );

    clksel_out #(.W(OUT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .nxt({nxt_n, nxt_m, nxt_r}),
        .q(out_q), .load_stb(load_stb)
    );

    assign {pll_n, pll_m, ratio_code} = out_q;
endmodule

// File: tb/clk_src_sel_tb.sv
`timescale 1ns/1ps
module clk_src_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] strap_code = 5'd7;
    logic       wdt_tmo = 1'b0;
    logic [7:0] pll_n;
    logic [6:0] pll_m;
    logic [4:0] ratio_code;
    logic       load_stb;

    int total = 0;
    int bad   = 0;

    // shadow of the register state, updated from the requirements
    logic [7:0] s_rn = '0, s_pn = '0, s_ln = '0;
    logic [6:0] s_rm = '0, s_pm = '0, s_lm = '0;
    logic       s_fl = 0, s_en = 0, s_ov = 0, s_act = 0;
    logic [4:0] s_sel = '0;
    logic [19:0] prev;

    always #2.5 clk = ~clk;

    clk_src_sel u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .strap_code(strap_code), .wdt_tmo(wdt_tmo), .pll_n(pll_n),
        .pll_m(pll_m), .ratio_code(ratio_code), .load_stb(load_stb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_bus();
        logic [7:0] sn, n;
        logic [6:0] m;
        logic [4:0] r;
        sn = 8'(50 + 6 * int'(strap_code));
        if (s_act && s_fl)  begin n = s_rn; m = s_rm; end
        else if (s_act)     begin n = sn;   m = 7'd48; end
        else if (s_en)      begin n = s_ln; m = s_lm; end
        else                begin n = sn;   m = 7'd48; end
        r = s_ov ? s_sel : strap_code;
        return {n, m, r};
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        case (a)
            0: return s_rn;
            1: return {s_fl, s_rm};
            2: return s_pn;
            3: return {1'b0, s_pm};
            4: return {5'b0, s_act, s_ov, s_en};
            5: return {3'b0, s_sel};
            default: return 8'h00;
        endcase
    endfunction

    // one edge, then compare outputs and strobe with the shadow model
    task automatic step(input string tag);
        logic [19:0] e;
        @(negedge clk);
        e = exp_bus();
        chk({tag, " pll_n"}, int'(pll_n), int'(e[19:12]));
        chk({tag, " pll_m"}, int'(pll_m), int'(e[11:5]));
        chk({tag, " ratio"}, int'(ratio_code), int'(e[4:0]));
        chk({tag, " R8/R9 load_stb"}, int'(load_stb), int'(e != prev));
        prev = e;
    endtask

    task automatic rd_chk(input int a, input string tag);
        rd_addr = 3'(a);
        #0.5;
        chk(tag, int'(rd_data), int'(exp_rd(a)));
    endtask

    task automatic wr(input int a, input int d, input logic tmo);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d); wdt_tmo = tmo;
        @(negedge clk);
        wr_en = 1'b0; wdt_tmo = 1'b0;
        case (a)
            0: s_rn = 8'(d);
            1: begin s_rm = 7'(d); s_fl = d[7]; end
            2: s_pn = 8'(d);
            3: begin s_pm = 7'(d); s_ln = s_pn; s_lm = 7'(d); end
            4: begin s_en = d[0]; s_ov = d[1]; if (d[2] && !tmo) s_act = 1'b0; end
            5: s_sel = 5'(d);
            default: ;
        endcase
        if (tmo) s_act = 1'b1;
    endtask

    task automatic pulse_tmo();
        @(negedge clk);
        wdt_tmo = 1'b1;
        @(negedge clk);
        wdt_tmo = 1'b0;
        s_act = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        for (int a = 0; a < 6; a++) rd_chk(a, "R1 reset readback");
        prev = exp_bus();
        chk("R1 reset pll_n", int'(pll_n), 92);
        chk("R1 reset pll_m", int'(pll_m), 48);
        chk("R1 reset ratio", int'(ratio_code), 7);
        chk("R1 reset load_stb", int'(load_stb), 0);
        rst_n = 1'b1;
        step("R1 after release");

        // R2 and R3: sweep every strap code with override clear
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            strap_code = 5'(c);
            step("R2 strap sweep");
        end
        step("R9 idle");

        // R3: override set, sweep every select value
        strap_code = 5'd9;
        step("R3 strap 9");
        wr(4, 8'h02, 1'b0);
        step("R3 override on");
        for (int s = 0; s < 32; s++) begin
            wr(5, s, 1'b0);
            rd_chk(5, "R10 sel readback");
            step("R3 select sweep");
        end
        wr(5, 31, 1'b0);
        step("R9 same select no strobe");

        // R4: programmable pair, staged by M writes
        wr(2, 100, 1'b0);
        step("R4 prgN while disabled");
        wr(4, 8'h03, 1'b0);
        step("R4 enable shows loaded pair");
        wr(3, 40, 1'b0);
        step("R4 M write loads");
        wr(2, 120, 1'b0);
        rd_chk(2, "R10 prgN readback");
        step("R4 N write alone holds");
        for (int m = 0; m < 128; m += 3) begin
            wr(2, 2 * m + 1, 1'b0);
            wr(3, m, 1'b0);
            step("R4 M sweep");
        end

        // R5 and R6: recovery with flag 0 uses strap pair
        wr(0, 200, 1'b0);
        wr(1, 8'h21, 1'b0);
        step("R9 recovery regs idle");
        pulse_tmo();
        rd_chk(4, "R5 recovery active readback");
        step("R5 time-out to strap pair");
        @(negedge clk);
        strap_code = 5'd20;
        step("R6 flag0 follows strap");
        wr(1, 8'hA1, 1'b0);
        step("R6 flag1 recovery pair");
        for (int n = 60; n < 250; n += 11) begin
            wr(0, n, 1'b0);
            step("R6 recN immediate");
        end
        wr(1, 8'h85, 1'b0);
        step("R6 recM immediate");
        wr(4, 8'h03, 1'b0);
        step("R7 ctrl write without clear keeps recovery");

        // R7: clear, and collision with a time-out
        wr(4, 8'h07, 1'b0);
        rd_chk(4, "R7 recovery cleared readback");
        step("R7 back to programmable");
        wr(4, 8'h07, 1'b1);
        rd_chk(4, "R7 time-out wins readback");
        step("R7 time-out wins");
        wr(4, 8'h06, 1'b0);
        step("R7 clear to strap");

        // R10: unmapped writes ignored
        wr(6, 8'hFF, 1'b0);
        step("R10 addr6 no effect");
        wr(7, 8'hFF, 1'b0);
        step("R10 addr7 no effect");
        for (int a = 0; a < 8; a++) rd_chk(a, "R10 readback after unmapped");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule